// File: doc/BRIEF.md
# Macro-op fusion pair detector

This block sits in the front end of a 64-bit RISC-V core. It looks at two neighbouring 32-bit instruction words in program order and decides whether the older one, called slot 0, and the younger one, called slot 1, can be merged into one internal operation. When they can, it reports a small fusion-kind code, the single destination register and the source registers that the fused operation still needs. When they cannot, it reports kind 0 and zero register fields.

The detector knows a fixed catalogue of pairs. Each pair is a producer that writes a temporary, followed by a consumer that overwrites that same temporary. A pair with a commutative consumer (ADD, ADDW, OR, MULW) may take the temporary on either operand. Both instruction words are decoded into an operation class and an immediate value. A pattern matcher and a lowest-code-wins encoder then choose the kind. The result is registered, so it appears one clock after the pair is presented.

Top module: `fuse_pair_det`

## Requirements
- R1: While `rst_n` is low, and at the first sample after reset is released with no valid pair presented, `fuse_o`, `kind_o`, `rd_o`, `src_a_o` and `src_b_o` are all zero.
- R2: The outputs describe the pair that was present at the previous rising clock edge. A fused result lasts exactly one cycle when the next pair does not fuse.
- R3: If `vld0_i` or `vld1_i` is low at a clock edge, every output is zero after that edge, whatever the instruction words are.
- R4: Kind 1 is SLLIW by 16 followed by SRLIW by 16. Kind 2 is SLLIW by 16 followed by SRAIW by 16. No other shift amount fuses.
- R5: Kind 3 is SLLI by 1, 2, 3 or 4 followed by ADD. Kind 6 is SRLI by 29, 30, 31 or 32 followed by ADD.
- R6: Kind 4 is SLLI by 32 followed by SRLI by 29, 30 or 31. Kind 5 is SRLI by 8 followed by ANDI with immediate 255.
- R7: A producer ANDI gives kind 7 with immediate 1 followed by ADD or ADDW. It gives kind 8 with immediate 127 followed by MULW. It gives kind 9 with immediate -256 (12-bit field 0xF00) followed by OR.
- R8: A producer ADDW gives kind 10 when followed by ANDI with immediate 1 or 255. It gives kind 11 when followed by ZEXT.H or SEXT.H.
- R9: A producer from the set AND, OR, XOR, ANDI (any immediate), ORI, XORI, ORC.B gives kind 12 when followed by ANDI 1. It gives kind 13 when followed by ZEXT.H.
- R10: A pair fuses only if the consumer's destination equals the producer's destination and that destination is not x0. A non-commutative consumer must also read the producer's destination through its first source field.
- R11: A commutative consumer (ADD, ADDW, OR, MULW) fuses only when exactly one of its two source fields names the producer's destination. A consumer with both sources equal to that register does not fuse.
- R12: When fused, `rd_o` is the shared destination and `src_a_o` is the producer's first source. `src_b_o` is the consumer's other source for a commutative consumer. Otherwise it is the producer's second source when the producer is a register-register op, and 0 when it is not.
- R13: `fuse_o` is high exactly when `kind_o` is nonzero. At most one catalogue pattern matches a pair. Any instruction outside the catalogue (for example SRAI, SUB) gives kind 0.
- R14: Encodings recognised (opcode, funct3, upper bits), listed here by instruction:
  - SLLI: 0x13, 1, imm[11:6]=0, shamt[25:20].
  - SRLI: 0x13, 5, imm[11:6]=0. SRAI: 0x13, 5, imm[11:6]=0x10.
  - ANDI: 0x13, 7. ORI: 0x13, 6. XORI: 0x13, 4.
  - ORC.B: 0x13, 5, imm 0x287. SEXT.H: 0x13, 1, imm 0x605.
  - SLLIW: 0x1B, 1, funct7 0, shamt[24:20]. SRLIW: 0x1B, 5, funct7 0. SRAIW: 0x1B, 5, funct7 0x20.
  - ADD: 0x33, 0, funct7 0. XOR: 0x33, 4. OR: 0x33, 6. AND: 0x33, 7, funct7 0. SUB: 0x33, 0, funct7 0x20.
  - ADDW: 0x3B, 0, funct7 0. MULW: 0x3B, 0, funct7 1.
  - ZEXT.H: 0x3B, 4, funct7 0x04, rs2 field 0. A nonzero rs2 field is not ZEXT.H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn0_i | input | 32 | Older instruction word (producer candidate) |
| vld0_i | input | 1 | Slot 0 holds a real instruction |
| insn1_i | input | 32 | Younger instruction word (consumer candidate) |
| vld1_i | input | 1 | Slot 1 holds a real instruction |
| fuse_o | output | 1 | Registered: the pair fuses |
| kind_o | output | 4 | Registered fusion kind, 0 means none |
| rd_o | output | 5 | Registered shared destination register |
| src_a_o | output | 5 | Registered first surviving source |
| src_b_o | output | 5 | Registered second surviving source, 0 if none |

## Verification
The main sweep crosses 94 producer shapes with 94 consumer shapes: every catalogue opcode, SRAI and SUB as near misses, shift amounts just inside and just outside each accepted set, and ANDI-family immediates 0, 1, 2, 127, 255 and -256. This separates each kind from its neighbours and from bit patterns that almost match. Every opcode pair is repeated under six register arrangements:
- temporary on the first source;
- temporary on the second source;
- temporary on both sources;
- mismatched destination;
- x0 destination;
- temporary on neither source.

These arrangements separate the linking rule, the commutative exactly-one rule and the choice of surviving source. Directed cases cover the valid-bit combinations, the one-cycle latency and a ZEXT.H word with a stray rs2 field.

// File: rtl/fuse_pkg.sv
package fuse_pkg;

  localparam int INSN_W    = 32;
  localparam int REG_W     = 5;
  localparam int IMM_W     = 12;
  localparam int NUM_KINDS = 13;
  localparam int KIND_W    = $clog2(NUM_KINDS + 1);
  localparam int NUM_SLOTS = 2;

  // Kind codes; a lower code wins when several patterns match.
  localparam int K_ZEXT16   = 1;
  localparam int K_SEXT16   = 2;
  localparam int K_SHL_ADD  = 3;
  localparam int K_ZEXTW_SH = 4;
  localparam int K_BYTE1    = 5;
  localparam int K_SHR_ADD  = 6;
  localparam int K_ADD_ODD  = 7;
  localparam int K_MUL7     = 8;
  localparam int K_BYTE_REP = 9;
  localparam int K_ADDW_MSK = 10;
  localparam int K_ADDW_EXT = 11;
  localparam int K_LOG_LSB  = 12;
  localparam int K_LOG_H16  = 13;

  typedef enum logic [4:0] {
    OP_NONE, OP_SLLIW, OP_SRLIW, OP_SRAIW, OP_SLLI, OP_SRLI,
    OP_ADD, OP_ADDW, OP_AND, OP_OR, OP_XOR, OP_ANDI, OP_ORI,
    OP_XORI, OP_ORCB, OP_MULW, OP_ZEXTH, OP_SEXTH
  } op_e;

  typedef struct packed {
    op_e              op;
    logic [REG_W-1:0] rd;
    logic [REG_W-1:0] rs1;
    logic [REG_W-1:0] rs2;
    logic [IMM_W-1:0] imm;     // shift amount (zero-extended) or I-immediate
    logic             reads_b; // register-register form
  } insn_t;

  function automatic insn_t decode_word(logic [INSN_W-1:0] w);
    insn_t d;
    logic [6:0]  opc;
    logic [2:0]  f3;
    logic [6:0]  f7;
    logic [11:0] i12;
    opc = w[6:0];
    f3  = w[14:12];
    f7  = w[31:25];
    i12 = w[31:20];
    d.op      = OP_NONE;
    d.rd      = w[11:7];
    d.rs1     = w[19:15];
    d.rs2     = w[24:20];
    d.imm     = i12;
    d.reads_b = 1'b0;
    case (opc)
      7'h13: begin
        case (f3)
          3'b001: begin
            if (w[31:26] == 6'h00) begin
              d.op  = OP_SLLI;
              d.imm = {6'h00, w[25:20]};
            end else if (i12 == 12'h605) d.op = OP_SEXTH;
          end
          3'b101: begin
            if (w[31:26] == 6'h00) begin
              d.op  = OP_SRLI;
              d.imm = {6'h00, w[25:20]};
            end else if (i12 == 12'h287) d.op = OP_ORCB;
          end
          3'b111:  d.op = OP_ANDI;
          3'b110:  d.op = OP_ORI;
          3'b100:  d.op = OP_XORI;
          default: d.op = OP_NONE;
        endcase
      end
      7'h1B: begin
        d.imm = {7'h00, w[24:20]};
        if (f3 == 3'b001 && f7 == 7'h00)      d.op = OP_SLLIW;
        else if (f3 == 3'b101 && f7 == 7'h00) d.op = OP_SRLIW;
        else if (f3 == 3'b101 && f7 == 7'h20) d.op = OP_SRAIW;
      end
      7'h33: begin
        if (f7 == 7'h00) begin
          d.reads_b = 1'b1;
          case (f3)
            3'b000:  d.op = OP_ADD;
            3'b111:  d.op = OP_AND;
            3'b110:  d.op = OP_OR;
            3'b100:  d.op = OP_XOR;
            default: begin
              d.op      = OP_NONE;
              d.reads_b = 1'b0;
            end
          endcase
        end
      end
      7'h3B: begin
        if (f3 == 3'b000 && f7 == 7'h00) begin
          d.op      = OP_ADDW;
          d.reads_b = 1'b1;
        end else if (f3 == 3'b000 && f7 == 7'h01) begin
          d.op      = OP_MULW;
          d.reads_b = 1'b1;
        end else if (f3 == 3'b100 && f7 == 7'h04 && w[24:20] == 5'd0) begin
          d.op = OP_ZEXTH;
        end
      end
      default: d.op = OP_NONE;
    endcase
    return d;
  endfunction

  function automatic logic is_commutable(op_e op);
    return (op == OP_ADD) || (op == OP_ADDW) || (op == OP_OR) || (op == OP_MULW);
  endfunction

  function automatic logic is_logic_op(op_e op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) || (op == OP_ANDI) ||
           (op == OP_ORI) || (op == OP_XORI) || (op == OP_ORCB);
  endfunction

  function automatic logic imm_is(logic [IMM_W-1:0] imm, int v);
    return imm == IMM_W'(v);
  endfunction

endpackage

// File: rtl/fuse_slot_dec.sv
module fuse_slot_dec
  import fuse_pkg::*;
(
  input  logic [INSN_W-1:0] word_i,
  output insn_t             dec_o
);
  always_comb dec_o = decode_word(word_i);
endmodule

// File: rtl/fuse_pair_match.sv
module fuse_pair_match
  import fuse_pkg::*;
(
  input  insn_t                prod_i,
  input  insn_t                cons_i,
  output logic [NUM_KINDS-1:0] pat_vec_o,
  output logic                 link_ok_o,
  output logic [NUM_KINDS-1:0] match_vec_o,
  output logic [REG_W-1:0]     src_b_o
);
  logic same_rd, hit1, hit2, comm;
  logic [NUM_KINDS-1:0] pat;

  always_comb begin
    same_rd   = (cons_i.rd == prod_i.rd) && (prod_i.rd != '0);
    hit1      = (cons_i.rs1 == prod_i.rd);
    hit2      = (cons_i.rs2 == prod_i.rd);
    comm      = is_commutable(cons_i.op);
    link_ok_o = same_rd && (comm ? (hit1 ^ hit2) : hit1);
  end

  always_comb begin
    pat = '0;
    pat[K_ZEXT16-1]   = prod_i.op == OP_SLLIW && imm_is(prod_i.imm, 16) &&
                        cons_i.op == OP_SRLIW && imm_is(cons_i.imm, 16);
    pat[K_SEXT16-1]   = prod_i.op == OP_SLLIW && imm_is(prod_i.imm, 16) &&
                        cons_i.op == OP_SRAIW && imm_is(cons_i.imm, 16);
    pat[K_SHL_ADD-1]  = prod_i.op == OP_SLLI && prod_i.imm >= IMM_W'(1) &&
                        prod_i.imm <= IMM_W'(4) && cons_i.op == OP_ADD;
    pat[K_ZEXTW_SH-1] = prod_i.op == OP_SLLI && imm_is(prod_i.imm, 32) &&
                        cons_i.op == OP_SRLI && cons_i.imm >= IMM_W'(29) &&
                        cons_i.imm <= IMM_W'(31);
    pat[K_BYTE1-1]    = prod_i.op == OP_SRLI && imm_is(prod_i.imm, 8) &&
                        cons_i.op == OP_ANDI && imm_is(cons_i.imm, 255);
    pat[K_SHR_ADD-1]  = prod_i.op == OP_SRLI && prod_i.imm >= IMM_W'(29) &&
                        prod_i.imm <= IMM_W'(32) && cons_i.op == OP_ADD;
    pat[K_ADD_ODD-1]  = prod_i.op == OP_ANDI && imm_is(prod_i.imm, 1) &&
                        (cons_i.op == OP_ADD || cons_i.op == OP_ADDW);
    pat[K_MUL7-1]     = prod_i.op == OP_ANDI && imm_is(prod_i.imm, 127) &&
                        cons_i.op == OP_MULW;
    pat[K_BYTE_REP-1] = prod_i.op == OP_ANDI && prod_i.imm == 12'hF00 &&
                        cons_i.op == OP_OR;
    pat[K_ADDW_MSK-1] = prod_i.op == OP_ADDW && cons_i.op == OP_ANDI &&
                        (imm_is(cons_i.imm, 1) || imm_is(cons_i.imm, 255));
    pat[K_ADDW_EXT-1] = prod_i.op == OP_ADDW &&
                        (cons_i.op == OP_ZEXTH || cons_i.op == OP_SEXTH);
    pat[K_LOG_LSB-1]  = is_logic_op(prod_i.op) && cons_i.op == OP_ANDI &&
                        imm_is(cons_i.imm, 1);
    pat[K_LOG_H16-1]  = is_logic_op(prod_i.op) && cons_i.op == OP_ZEXTH;
  end

  assign pat_vec_o   = pat;
  assign match_vec_o = link_ok_o ? pat : '0;

  always_comb begin
    if (comm)                src_b_o = hit1 ? cons_i.rs2 : cons_i.rs1;
    else if (prod_i.reads_b) src_b_o = prod_i.rs2;
    else                     src_b_o = '0;
  end
endmodule

// File: rtl/fuse_kind_enc.sv
module fuse_kind_enc
  import fuse_pkg::*;
(
  input  logic [NUM_KINDS-1:0] match_vec_i,
  output logic [KIND_W-1:0]    kind_o
);
  always_comb begin
    kind_o = '0;
    for (int k = NUM_KINDS - 1; k >= 0; k--) begin
      if (match_vec_i[k]) kind_o = KIND_W'(k + 1);
    end
  end
endmodule

// File: rtl/fuse_pair_det.sv
module fuse_pair_det
  import fuse_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INSN_W-1:0] insn0_i,
  input  logic              vld0_i,
  input  logic [INSN_W-1:0] insn1_i,
  input  logic              vld1_i,
  output logic              fuse_o,
  output logic [KIND_W-1:0] kind_o,
  output logic [REG_W-1:0]  rd_o,
  output logic [REG_W-1:0]  src_a_o,
  output logic [REG_W-1:0]  src_b_o
);
  logic [INSN_W-1:0] words [NUM_SLOTS];
  insn_t             dec   [NUM_SLOTS];

  assign words[0] = insn0_i;
  assign words[1] = insn1_i;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    fuse_slot_dec u_dec (.word_i(words[g]), .dec_o(dec[g]));
  end

  logic [NUM_KINDS-1:0] pat_vec, match_vec;
  logic                 link_ok;
  logic [REG_W-1:0]     src_b_c;
  logic [KIND_W-1:0]    kind_c;

  fuse_pair_match u_match (
    .prod_i      (dec[0]),
    .cons_i      (dec[1]),
    .pat_vec_o   (pat_vec),
    .link_ok_o   (link_ok),
    .match_vec_o (match_vec),
    .src_b_o     (src_b_c)
  );

  fuse_kind_enc u_enc (.match_vec_i(match_vec), .kind_o(kind_c));

  // Named events for the checker.
  logic              pair_vld;
  logic              fuse_nxt;
  logic [KIND_W-1:0] kind_nxt;

  assign pair_vld = vld0_i && vld1_i;
  assign kind_nxt = pair_vld ? kind_c : '0;
  assign fuse_nxt = kind_nxt != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fuse_o  <= 1'b0;
      kind_o  <= '0;
      rd_o    <= '0;
      src_a_o <= '0;
      src_b_o <= '0;
    end else begin
      fuse_o  <= fuse_nxt;
      kind_o  <= kind_nxt;
      rd_o    <= fuse_nxt ? dec[0].rd  : '0;
      src_a_o <= fuse_nxt ? dec[0].rs1 : '0;
      src_b_o <= fuse_nxt ? src_b_c    : '0;
    end
  end
endmodule

// File: rtl/fuse_pair_det_chk.sv
module fuse_pair_det_chk
  import fuse_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 pair_vld,
  input logic                 fuse_nxt,
  input logic [KIND_W-1:0]    kind_nxt,
  input logic [NUM_KINDS-1:0] pat_vec,
  input logic                 link_ok,
  input logic                 fuse_o,
  input logic [KIND_W-1:0]    kind_o,
  input logic [REG_W-1:0]     rd_o,
  input logic [REG_W-1:0]     src_a_o
);
  a_r3_invalid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_vld |=> (!fuse_o && kind_o == '0 && rd_o == '0 && src_a_o == '0));

  a_r2_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (fuse_o == $past(fuse_nxt) && kind_o == $past(kind_nxt)));

  a_r13_flag_code: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_o == (kind_o != '0));

  a_r13_single_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pat_vec));

  a_r10_dest_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_o |-> rd_o != '0);

  a_r10_link_needed: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_nxt |-> link_ok);
endmodule

bind fuse_pair_det fuse_pair_det_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pair_vld (pair_vld),
  .fuse_nxt (fuse_nxt),
  .kind_nxt (kind_nxt),
  .pat_vec  (pat_vec),
  .link_ok  (link_ok),
  .fuse_o   (fuse_o),
  .kind_o   (kind_o),
  .rd_o     (rd_o),
  .src_a_o  (src_a_o)
);

// File: tb/fuse_pair_det_test.sv
`timescale 1ns/1ps
module fuse_pair_det_test;
  localparam int SLLIW = 0, SRLIW = 1, SRAIW = 2, SLLI = 3, SRLI = 4, SRAI = 5;
  localparam int ADD = 6, ADDW = 7, AND_ = 8, OR_ = 9, XOR_ = 10, ANDI = 11;
  localparam int ORI = 12, XORI = 13, ORCB = 14, MULW = 15, ZEXTH = 16;
  localparam int SEXTH = 17, SUB = 18, NOPS = 19;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] insn0 = '0, insn1 = '0;
  logic        vld0 = 1'b0, vld1 = 1'b0;
  logic        fuse;
  logic [3:0]  kind;
  logic [4:0]  rd, src_a, src_b;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  fuse_pair_det uut (
    .clk(clk), .rst_n(rst_n), .insn0_i(insn0), .vld0_i(vld0),
    .insn1_i(insn1), .vld1_i(vld1), .fuse_o(fuse), .kind_o(kind),
    .rd_o(rd), .src_a_o(src_a), .src_b_o(src_b)
  );

  function automatic logic [31:0] mk(int op, int rdv, int s1v, int s2v, int imm);
    logic [4:0]  d, a, b;
    logic [31:0] iv;
    d = rdv[4:0]; a = s1v[4:0]; b = s2v[4:0]; iv = imm;
    case (op)
      SLLIW: return {7'h00, iv[4:0], a, 3'd1, d, 7'h1B};
      SRLIW: return {7'h00, iv[4:0], a, 3'd5, d, 7'h1B};
      SRAIW: return {7'h20, iv[4:0], a, 3'd5, d, 7'h1B};
      SLLI:  return {6'h00, iv[5:0], a, 3'd1, d, 7'h13};
      SRLI:  return {6'h00, iv[5:0], a, 3'd5, d, 7'h13};
      SRAI:  return {6'h10, iv[5:0], a, 3'd5, d, 7'h13};
      ADD:   return {7'h00, b, a, 3'd0, d, 7'h33};
      ADDW:  return {7'h00, b, a, 3'd0, d, 7'h3B};
      AND_:  return {7'h00, b, a, 3'd7, d, 7'h33};
      OR_:   return {7'h00, b, a, 3'd6, d, 7'h33};
      XOR_:  return {7'h00, b, a, 3'd4, d, 7'h33};
      ANDI:  return {iv[11:0], a, 3'd7, d, 7'h13};
      ORI:   return {iv[11:0], a, 3'd6, d, 7'h13};
      XORI:  return {iv[11:0], a, 3'd4, d, 7'h13};
      ORCB:  return {12'h287, a, 3'd5, d, 7'h13};
      MULW:  return {7'h01, b, a, 3'd0, d, 7'h3B};
      ZEXTH: return {7'h04, 5'd0, a, 3'd4, d, 7'h3B};
      SEXTH: return {12'h605, a, 3'd1, d, 7'h13};
      default: return {7'h20, b, a, 3'd0, d, 7'h33}; // SUB
    endcase
  endfunction

  function automatic int shv(int i);
    case (i)
      0: return 1;   1: return 2;   2: return 3;   3: return 4;
      4: return 5;   5: return 8;   6: return 16;  7: return 29;
      8: return 30;  9: return 31;  10: return 32; default: return 33;
    endcase
  endfunction

  function automatic int lgv(int i);
    case (i)
      0: return 1; 1: return 127; 2: return 255; 3: return -256; 4: return 0; default: return 2;
    endcase
  endfunction

  function automatic int nimm(int op);
    if (op <= SRAIW) return 10;
    if (op <= SRAI) return 12;
    if (op >= ANDI && op <= XORI) return 6;
    return 1;
  endfunction

  function automatic int immof(int op, int i);
    if (op <= SRAI) return shv(i);
    if (op >= ANDI && op <= XORI) return lgv(i);
    return 0;
  endfunction

  function automatic bit in_set(int v, int lo, int hi);
    return v >= lo && v <= hi;
  endfunction

  // Kind from the catalogue (R4..R9), ignoring registers.
  function automatic int ek(int p, int pi, int c, int ci);
    bit lg;
    lg = (p == AND_ || p == OR_ || p == XOR_ || p == ANDI || p == ORI || p == XORI || p == ORCB);
    if (p == SLLIW && pi == 16 && c == SRLIW && ci == 16) return 1;
    if (p == SLLIW && pi == 16 && c == SRAIW && ci == 16) return 2;
    if (p == SLLI && in_set(pi, 1, 4) && c == ADD) return 3;
    if (p == SLLI && pi == 32 && c == SRLI && in_set(ci, 29, 31)) return 4;
    if (p == SRLI && pi == 8 && c == ANDI && ci == 255) return 5;
    if (p == SRLI && in_set(pi, 29, 32) && c == ADD) return 6;
    if (p == ANDI && pi == 1 && (c == ADD || c == ADDW)) return 7;
    if (p == ANDI && pi == 127 && c == MULW) return 8;
    if (p == ANDI && pi == -256 && c == OR_) return 9;
    if (p == ADDW && c == ANDI && (ci == 1 || ci == 255)) return 10;
    if (p == ADDW && (c == ZEXTH || c == SEXTH)) return 11;
    if (lg && c == ANDI && ci == 1) return 12;
    if (lg && c == ZEXTH) return 13;
    return 0;
  endfunction

  function automatic string req_tag(int k, int sc);
    if (k == 1 || k == 2) return "R4/R12";
    if (k == 3 || k == 6) return "R5/R12";
    if (k == 4 || k == 5) return "R6/R12";
    if (k >= 7 && k <= 9) return "R7/R12";
    if (k == 10 || k == 11) return "R8/R12";
    if (k >= 12) return "R9/R12";
    if (sc == 1 || sc == 2) return "R11";
    if (sc >= 3) return "R10";
    return "R13";
  endfunction

  task automatic check_out(string tag, logic ef, int ekind, int erd, int ea, int eb);
    checks++;
    if (fuse !== ef || kind !== 4'(ekind) || rd !== 5'(erd) ||
        src_a !== 5'(ea) || src_b !== 5'(eb)) begin
      errors++;
      $display("FAIL %s: got fuse=%0b kind=%0d rd=%0d a=%0d b=%0d, expected fuse=%0b kind=%0d rd=%0d a=%0d b=%0d (%h %h)",
               tag, fuse, kind, rd, src_a, src_b, ef, ekind, erd, ea, eb, insn0, insn1);
    end
  endtask

  task automatic run_pair(int p, int pi, int c, int ci, int sc);
    int  rd1, rd2, c1, c2, k, eb;
    bit  comm, ok, pbin;
    case (sc)
      0: begin rd1 = 5;  rd2 = 5;  c1 = 5;  c2 = 7; end
      1: begin rd1 = 31; rd2 = 31; c1 = 7;  c2 = 31; end
      2: begin rd1 = 1;  rd2 = 1;  c1 = 1;  c2 = 1; end
      3: begin rd1 = 5;  rd2 = 6;  c1 = 5;  c2 = 7; end
      4: begin rd1 = 0;  rd2 = 0;  c1 = 0;  c2 = 7; end
      default: begin rd1 = 20; rd2 = 20; c1 = 7; c2 = 9; end
    endcase
    comm = (c == ADD || c == ADDW || c == OR_ || c == MULW);
    pbin = (p == ADD || p == ADDW || p == AND_ || p == OR_ || p == XOR_ || p == MULW || p == SUB);
    ok = (sc == 0) || (sc == 1 && comm) || (sc == 2 && !comm);
    k = ok ? ek(p, pi, c, ci) : 0;
    eb = comm ? 7 : (pbin ? 12 : 0);
    insn0 = mk(p, rd1, 11, 12, pi);
    insn1 = mk(c, rd2, c1, c2, ci);
    vld0 = 1'b1; vld1 = 1'b1;
    @(posedge clk); #2;
    if (k != 0) check_out(req_tag(k, sc), 1'b1, k, rd1, 11, eb);
    else        check_out(req_tag(ek(p, pi, c, ci) != 0 ? 0 : 99, sc), 1'b0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check_out("R1", 1'b0, 0, 0, 0, 0);
    rst_n = 1'b1;
    @(posedge clk); #2;
    check_out("R1", 1'b0, 0, 0, 0, 0);

    // R3: every valid combination other than both high kills fusion.
    for (int v = 0; v < 4; v++) begin
      insn0 = mk(SLLIW, 9, 4, 0, 16);
      insn1 = mk(SRLIW, 9, 9, 0, 16);
      vld0 = v[0]; vld1 = v[1];
      @(posedge clk); #2;
      if (v == 3) check_out("R3", 1'b1, 1, 9, 4, 0);
      else        check_out("R3", 1'b0, 0, 0, 0, 0);
    end

    // R2: result lasts one cycle after the pair is withdrawn.
    insn0 = mk(SLLI, 8, 3, 0, 2);
    insn1 = mk(ADD, 8, 13, 8, 0);
    vld0 = 1'b1; vld1 = 1'b1;
    @(posedge clk); #2;
    check_out("R2", 1'b1, 3, 8, 3, 13);
    vld1 = 1'b0;
    @(posedge clk); #2;
    check_out("R2", 1'b0, 0, 0, 0, 0);

    // R14: ZEXT.H with a nonzero rs2 field is a different instruction.
    insn0 = mk(ADDW, 8, 3, 4, 0);
    insn1 = mk(ZEXTH, 8, 8, 0, 0) | 32'h0010_0000;
    vld0 = 1'b1; vld1 = 1'b1;
    @(posedge clk); #2;
    check_out("R14", 1'b0, 0, 0, 0, 0);

    // Main sweep over producer x consumer x register arrangement (R4..R13).
    for (int p = 0; p < NOPS; p++)
      for (int pi = 0; pi < nimm(p); pi++)
        for (int c = 0; c < NOPS; c++)
          for (int ci = 0; ci < nimm(c); ci++)
            for (int sc = 0; sc < 6; sc++)
              run_pair(p, immof(p, pi), c, immof(c, ci), sc);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule